// File: doc/BRIEF.md
# Operand Fetch Stage

This block is the operand-gathering step of a five-step instruction pipeline. It receives the opcode, the 4-bit register field and the effective address produced by the address step. From these it assembles the two ALU inputs that the operate step needs. Two mode bits in the opcode decide where each operand comes from.

- Operand A is either a register-file word or the register field itself, zero-extended as a short immediate.
- Operand B is either a memory word read at the effective address, or the effective address itself used as a long immediate.

The stage owns one register-file read port and one memory read port. Each port carries its own "needed" flag, so an unused port can stay idle. Read data is expected back in the same cycle as the request.

The decoded source choice is held in an enumerated mode with four values:

| Mode | Register read | Memory read | Operand A | Operand B |
|---|---|---|---|---|
| `MODE_SHORT_ADDR` | no | no | register field | address |
| `MODE_SHORT_MEM` | no | yes | register field | memory word |
| `MODE_REG_ADDR` | yes | no | register word | address |
| `MODE_REG_MEM` | yes | yes | register word | memory word |

There is no other sequencing. Every cycle the mode is decoded afresh from the incoming opcode, so any mode may follow any other, including itself. On each rising clock edge the opcode, register field, address and both operands are captured into the output register for the operate step.

Top module: `operand_fetch_stage`

## Requirements
- R1: The register read index `rf_idx` equals the incoming register field `in_r` in the same cycle, whatever the mode.
- R2: `rf_need` equals opcode bit 3, the register-read mode bit, in the same cycle.
- R3: `mem_need` equals opcode bit 2, the memory-read mode bit. In the same cycle, `mem_addr` equals `in_ea`.
- R4: When opcode bit 3 is 1, `out_opa` after the next rising edge equals the `rf_rdata` present before that edge.
- R5: When opcode bit 3 is 0, `out_opa` after the next rising edge equals `in_r` zero-extended to the data width.
- R6: When opcode bit 2 is 1, `out_opb` after the next rising edge equals the `mem_rdata` present before that edge.
- R7: When opcode bit 2 is 0, `out_opb` after the next rising edge equals `in_ea` zero-extended to the data width.
- R8: `out_op`, `out_r` and `out_ea` after each rising edge equal `in_op`, `in_r` and `in_ea` from before that edge, unchanged.
- R9: While `rst_n` is low, every registered output is zero.
- R10: Opcode bits 7..4 and 1..0 have no effect on which source feeds either operand, nor on either needed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_op | input | 8 | Opcode; bit 3 selects register read, bit 2 selects memory read |
| in_r | input | 4 | Register field |
| in_ea | input | 16 | Effective address from the address step |
| rf_idx | output | 4 | Register file read index |
| rf_need | output | 1 | Register read port needed |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| mem_addr | output | 16 | Memory read address |
| mem_need | output | 1 | Memory read port needed |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| out_op | output | 8 | Registered opcode |
| out_r | output | 4 | Registered register field |
| out_ea | output | 16 | Registered effective address |
| out_opa | output | 32 | Registered operand A |
| out_opb | output | 32 | Registered operand B |

## Verification
The port requests are combinational, so the index, address and both needed flags are due in the same cycle as the inputs. The bench drives inputs on the falling edge and samples these outputs 1 ns later. The registered fields and both operands are due one rising edge later. The bench samples them 1 ns after that edge, before it drives the next inputs, so each registered result is compared with the vector that produced it.

The bench's register and memory models answer combinationally from the index and address. This makes a wrong source visible as a wrong value.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Operand source mode, decoded from the two mode bits of the opcode.
    typedef enum logic [1:0] {
        MODE_SHORT_ADDR = 2'b00,   // opa = short field, opb = address
        MODE_SHORT_MEM  = 2'b01,   // opa = short field, opb = memory word
        MODE_REG_ADDR   = 2'b10,   // opa = register,    opb = address
        MODE_REG_MEM    = 2'b11    // opa = register,    opb = memory word
    } ofs_mode_e;

    // Port request bundle produced by the decoder.
    typedef struct packed {
        logic rf_rd;
        logic mem_rd;
    } ofs_req_t;

endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
    import ofs_pkg::*;
(
    input  logic      reg_bit,
    input  logic      mem_bit,
    output ofs_mode_e mode,
    output ofs_req_t  req
);

    always_comb begin
        mode = ofs_mode_e'({reg_bit, mem_bit});
    end

    always_comb begin
        req = '0;
        unique case (mode)
            MODE_SHORT_ADDR: begin
                req.rf_rd  = 1'b0;
                req.mem_rd = 1'b0;
            end
            MODE_SHORT_MEM: begin
                req.rf_rd  = 1'b0;
                req.mem_rd = 1'b1;
            end
            MODE_REG_ADDR: begin
                req.rf_rd  = 1'b1;
                req.mem_rd = 1'b0;
            end
            MODE_REG_MEM: begin
                req.rf_rd  = 1'b1;
                req.mem_rd = 1'b1;
            end
            default: req = '0;
        endcase
    end

endmodule

// File: rtl/ofs_opa_sel.sv
module ofs_opa_sel
    import ofs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RIDX_W = 4
) (
    input  ofs_mode_e          mode,
    input  logic [RIDX_W-1:0]  short_val,
    input  logic [DATA_W-1:0]  rf_word,
    output logic [DATA_W-1:0]  opa
);

    localparam int PAD_W = DATA_W - RIDX_W;

    logic [DATA_W-1:0] short_ext;

    assign short_ext = {{PAD_W{1'b0}}, short_val};

    always_comb begin
        opa = '0;
        unique case (mode)
            MODE_SHORT_ADDR,
            MODE_SHORT_MEM:  opa = short_ext;
            MODE_REG_ADDR,
            MODE_REG_MEM:    opa = rf_word;
            default:         opa = '0;
        endcase
    end

endmodule

// File: rtl/ofs_opb_sel.sv
module ofs_opb_sel
    import ofs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  ofs_mode_e          mode,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  mem_word,
    output logic [DATA_W-1:0]  opb
);

    localparam int PAD_W = (DATA_W > ADDR_W) ? (DATA_W - ADDR_W) : 1;

    logic [DATA_W-1:0] addr_ext;

    generate
        if (ADDR_W == DATA_W) begin : g_same_width
            assign addr_ext = addr;
        end else begin : g_zero_extend
            logic [PAD_W-1:0] pad;
            assign pad      = '0;
            assign addr_ext = {pad, addr};
        end
    endgenerate

    always_comb begin
        opb = '0;
        unique case (mode)
            MODE_SHORT_ADDR,
            MODE_REG_ADDR:   opb = addr_ext;
            MODE_SHORT_MEM,
            MODE_REG_MEM:    opb = mem_word;
            default:         opb = '0;
        endcase
    end

endmodule

// File: rtl/ofs_stage_reg.sv
module ofs_stage_reg #(
    parameter int OP_W   = 8,
    parameter int RIDX_W = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    d_op,
    input  logic [RIDX_W-1:0]  d_r,
    input  logic [ADDR_W-1:0]  d_ea,
    input  logic [DATA_W-1:0]  d_opa,
    input  logic [DATA_W-1:0]  d_opb,
    output logic [OP_W-1:0]    q_op,
    output logic [RIDX_W-1:0]  q_r,
    output logic [ADDR_W-1:0]  q_ea,
    output logic [DATA_W-1:0]  q_opa,
    output logic [DATA_W-1:0]  q_opb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_op  <= '0;
            q_r   <= '0;
            q_ea  <= '0;
            q_opa <= '0;
            q_opb <= '0;
        end else begin
            q_op  <= d_op;
            q_r   <= d_r;
            q_ea  <= d_ea;
            q_opa <= d_opa;
            q_opb <= d_opb;
        end
    end

endmodule

// File: rtl/operand_fetch_stage.sv
module operand_fetch_stage
    import ofs_pkg::*;
#(
    parameter int OP_W     = 8,
    parameter int RIDX_W   = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int REG_BIT  = 3,
    parameter int MEM_BIT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    in_op,
    input  logic [RIDX_W-1:0]  in_r,
    input  logic [ADDR_W-1:0]  in_ea,
    output logic [RIDX_W-1:0]  rf_idx,
    output logic               rf_need,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_need,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [OP_W-1:0]    out_op,
    output logic [RIDX_W-1:0]  out_r,
    output logic [ADDR_W-1:0]  out_ea,
    output logic [DATA_W-1:0]  out_opa,
    output logic [DATA_W-1:0]  out_opb
);

    ofs_mode_e         mode;
    ofs_req_t          req;
    logic [DATA_W-1:0] opa_d;
    logic [DATA_W-1:0] opb_d;

    ofs_mode_decode u_dec (
        .reg_bit (in_op[REG_BIT]),
        .mem_bit (in_op[MEM_BIT]),
        .mode    (mode),
        .req     (req)
    );

    assign rf_idx   = in_r;
    assign rf_need  = req.rf_rd;
    assign mem_addr = in_ea;
    assign mem_need = req.mem_rd;

    ofs_opa_sel #(
        .DATA_W (DATA_W),
        .RIDX_W (RIDX_W)
    ) u_opa (
        .mode      (mode),
        .short_val (in_r),
        .rf_word   (rf_rdata),
        .opa       (opa_d)
    );

    ofs_opb_sel #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_opb (
        .mode     (mode),
        .addr     (in_ea),
        .mem_word (mem_rdata),
        .opb      (opb_d)
    );

    ofs_stage_reg #(
        .OP_W   (OP_W),
        .RIDX_W (RIDX_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_op  (in_op),
        .d_r   (in_r),
        .d_ea  (in_ea),
        .d_opa (opa_d),
        .d_opb (opb_d),
        .q_op  (out_op),
        .q_r   (out_r),
        .q_ea  (out_ea),
        .q_opa (out_opa),
        .q_opb (out_opb)
    );

endmodule

// File: rtl/ofs_checker.sv
module ofs_checker #(
    parameter int OP_W    = 8,
    parameter int RIDX_W  = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int REG_BIT = 3,
    parameter int MEM_BIT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    in_op,
    input logic [RIDX_W-1:0]  in_r,
    input logic [ADDR_W-1:0]  in_ea,
    input logic [RIDX_W-1:0]  rf_idx,
    input logic               rf_need,
    input logic [DATA_W-1:0]  rf_rdata,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_need,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic [OP_W-1:0]    out_op,
    input logic [RIDX_W-1:0]  out_r,
    input logic [ADDR_W-1:0]  out_ea,
    input logic [DATA_W-1:0]  out_opa,
    input logic [DATA_W-1:0]  out_opb
);

    assert_rf_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_idx == in_r);

    assert_rf_need_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_need == in_op[REG_BIT]);

    assert_mem_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_need == in_op[MEM_BIT]) && (mem_addr == in_ea));

    assert_opa_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_op[REG_BIT] |=> out_opa == $past(rf_rdata));

    assert_opa_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_op[REG_BIT] |=> out_opa == DATA_W'($past(in_r)));

    assert_opb_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_op[MEM_BIT] |=> out_opb == $past(mem_rdata));

    assert_opb_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_op[MEM_BIT] |=> out_opb == DATA_W'($past(in_ea)));

    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_op == $past(in_op)) && (out_r == $past(in_r))
                 && (out_ea == $past(in_ea)));

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R9: assert (out_op == '0 && out_r == '0 && out_ea == '0
                                          && out_opa == '0 && out_opb == '0);
        end
    end

endmodule

bind operand_fetch_stage ofs_checker #(
    .OP_W    (OP_W),
    .RIDX_W  (RIDX_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_BIT (REG_BIT),
    .MEM_BIT (MEM_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_op     (in_op),
    .in_r      (in_r),
    .in_ea     (in_ea),
    .rf_idx    (rf_idx),
    .rf_need   (rf_need),
    .rf_rdata  (rf_rdata),
    .mem_addr  (mem_addr),
    .mem_need  (mem_need),
    .mem_rdata (mem_rdata),
    .out_op    (out_op),
    .out_r     (out_r),
    .out_ea    (out_ea),
    .out_opa   (out_opa),
    .out_opb   (out_opb)
);

// File: tb/sim_operand_fetch_stage.sv
`timescale 1ns/1ps
module sim_operand_fetch_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_op = '0;
    logic [3:0]  in_r = '0;
    logic [15:0] in_ea = '0;
    logic [3:0]  rf_idx;
    logic        rf_need;
    logic [31:0] rf_rdata;
    logic [15:0] mem_addr;
    logic        mem_need;
    logic [31:0] mem_rdata;
    logic [7:0]  out_op;
    logic [3:0]  out_r;
    logic [15:0] out_ea;
    logic [31:0] out_opa;
    logic [31:0] out_opb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    // Register file and memory models answer in the same cycle.
    function automatic logic [31:0] rf_model(input logic [3:0] idx);
        return 32'h9E3779B9 * ({28'd0, idx} + 32'd1);
    endfunction

    function automatic logic [31:0] mem_model(input logic [15:0] a);
        return {a[7:0], a, a[15:8]} ^ 32'h5A5A_C3C3;
    endfunction

    assign rf_rdata  = rf_model(rf_idx);
    assign mem_rdata = mem_model(mem_addr);

    function automatic logic [31:0] exp_opa(input logic [7:0] op, input logic [3:0] r);
        return op[3] ? rf_model(r) : {28'd0, r};
    endfunction

    function automatic logic [31:0] exp_opb(input logic [7:0] op, input logic [15:0] ea);
        return op[2] ? mem_model(ea) : {16'd0, ea};
    endfunction

    operand_fetch_stage u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_op     (in_op),
        .in_r      (in_r),
        .in_ea     (in_ea),
        .rf_idx    (rf_idx),
        .rf_need   (rf_need),
        .rf_rdata  (rf_rdata),
        .mem_addr  (mem_addr),
        .mem_need  (mem_need),
        .mem_rdata (mem_rdata),
        .out_op    (out_op),
        .out_r     (out_r),
        .out_ea    (out_ea),
        .out_opa   (out_opa),
        .out_opb   (out_opb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector, check same-cycle ports, then registered outputs.
    task automatic apply(input logic [7:0] op, input logic [3:0] r, input logic [15:0] ea,
                         input bit tag_r10);
        @(negedge clk);
        in_op = op;
        in_r  = r;
        in_ea = ea;
        #1;
        chk("R1 rf_idx", {28'd0, rf_idx}, {28'd0, r});
        chk("R2 rf_need", {31'd0, rf_need}, {31'd0, op[3]});
        chk("R3 mem_need", {31'd0, mem_need}, {31'd0, op[2]});
        chk("R3 mem_addr", {16'd0, mem_addr}, {16'd0, ea});
        @(posedge clk);
        #1;
        if (op[3]) chk("R4 opa register", out_opa, exp_opa(op, r));
        else       chk("R5 opa short", out_opa, exp_opa(op, r));
        if (op[2]) chk("R6 opb memory", out_opb, exp_opb(op, ea));
        else       chk("R7 opb address", out_opb, exp_opb(op, ea));
        chk("R8 out_op", {24'd0, out_op}, {24'd0, op});
        chk("R8 out_r", {28'd0, out_r}, {28'd0, r});
        chk("R8 out_ea", {16'd0, out_ea}, {16'd0, ea});
        if (tag_r10) begin
            chk("R10 opa unaffected", out_opa, exp_opa(op, r));
            chk("R10 opb unaffected", out_opb, exp_opb(op, ea));
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        in_op = 8'hFF;
        in_r  = 4'hF;
        in_ea = 16'hBEEF;
        repeat (3) @(negedge clk);
        chk("R9 reset out_op", {24'd0, out_op}, 32'd0);
        chk("R9 reset out_r", {28'd0, out_r}, 32'd0);
        chk("R9 reset out_ea", {16'd0, out_ea}, 32'd0);
        chk("R9 reset out_opa", out_opa, 32'd0);
        chk("R9 reset out_opb", out_opb, 32'd0);
        rst_n = 1'b1;

        // Directed: every mode, edge field values.
        for (int m = 0; m < 4; m++) begin
            apply({4'h0, m[1:0], 2'b00}, 4'h0, 16'h0000, 1'b0);
            apply({4'hF, m[1:0], 2'b11}, 4'hF, 16'hFFFF, 1'b0);
            apply({4'hA, m[1:0], 2'b01}, 4'h7, 16'h8001, 1'b0);
        end
        // R10: same mode and fields, other opcode bits varied.
        for (int m = 0; m < 4; m++) begin
            apply({4'h3, m[1:0], 2'b10}, 4'h9, 16'h1234, 1'b1);
            apply({4'hC, m[1:0], 2'b01}, 4'h9, 16'h1234, 1'b1);
        end
        // Back-to-back mode changes.
        apply(8'h0C, 4'h5, 16'h00F0, 1'b0);
        apply(8'h00, 4'h5, 16'h00F0, 1'b0);
        apply(8'h04, 4'h2, 16'h0F00, 1'b0);
        apply(8'h08, 4'h2, 16'h0F00, 1'b0);
        // Random stimulus.
        for (int i = 0; i < 300; i++) begin
            apply($urandom() & 8'hFF, $urandom() & 4'hF, $urandom() & 16'hFFFF, 1'b1);
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule